// File: doc/BRIEF.md
# Predicated Stack-Relative Multi-Element Load/Store Sequencer

This block steps through the elements of one vectorised stack-relative load or store, so that a single instruction moves a group of registers to or from the stack. A start pulse captures the element count, a predicate mask for the memory (source) side and one for the register (destination) side, a vector flag for each side, the destination register number as it comes out of the register-redirection table, and the base byte offset. The stack pointer is always the implicit memory base and is never redirected.

The block keeps two element cursors, one for each side. A vectorised side skips every element whose predicate bit is clear. Each surviving pair of elements becomes one request on a valid/ready port. The request carries a byte offset from the stack pointer and a target register number. When the stack pointer side is vectorised, the offset moves up by four bytes per element and the register number of the stack pointer stays the same. A side that is scalar stays on element 0 and its mask has no effect. The sequence ends when either cursor passes the element count, or after one request when neither side is vectorised. The end is marked by a single-cycle done pulse.

Top module: `spmulti_seq`

## Requirements
- R1: Under reset (rst_n low, sampled on the clock edge) and right after it, req_valid_o, busy_o and done_o are 0.
- R2: A start pulse is accepted only while busy_o is 0. A start pulse seen while busy is ignored: the running sequence is unchanged and no second sequence follows it.
- R3: A count of 0 produces no request and exactly one done pulse.
- R4: With the source side vectorised, request k carries offset (imm + 4*i) mod 2^OFF_W, where i is the position of the k-th set bit of src_mask_i below the count. Cleared bits are skipped. Offsets rise in element order.
- R5: With the destination side vectorised, request k carries register (dst_reg + j) mod 2^REG_W, where j is the position of the k-th set bit of dst_mask_i below the count. Positions rise.
- R6: With both sides vectorised, the number of requests is the smaller of the two counts of set mask bits below the element count.
- R7: A scalar side keeps its field at its base value (offset imm, or register dst_reg) and its mask is ignored. The number of requests equals the set-bit count of the vectorised side.
- R8: With neither side vectorised and a count above 0, exactly one request (offset imm, register dst_reg) is issued whatever the masks hold.
- R9: While req_valid_o is 1 and req_ready_i is 0, the request stays valid and its offset and register do not change. The cursors move only on a completed handshake.
- R10: done_o is a one-cycle pulse that appears after the last handshake, and busy_o is 0 while done_o is high.
- R11: An element count above ELEMS is treated as ELEMS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sequence with the configuration below |
| vl_i | input | IW | Element count |
| src_vec_i | input | 1 | Stack pointer side is vectorised |
| src_mask_i | input | ELEMS | Source predicate, bit n for element n |
| dst_vec_i | input | 1 | Destination register is vectorised |
| dst_mask_i | input | ELEMS | Destination predicate, bit n for element n |
| dst_reg_i | input | REG_W | Redirected destination register number |
| imm_i | input | OFF_W | Base byte offset from the stack pointer |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_off_o | output | OFF_W | Byte offset of the element from the stack pointer |
| req_reg_o | output | REG_W | Target register number |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
If a cursor holds a wrong value, the very next accepted request shows an offset or register number that does not match the predicate walk. A cursor that slipped during a stall shows up one cycle after the stall began, as a field that changed while it was held. If the run/idle state is wrong, the result is a request with busy low, an extra or missing request, or a done pulse that is absent or longer than one cycle. All of these are visible within the sequence that caused them. Sweeps over every count with mixed masks and a pseudo-random ready pattern compare each request against a walk computed in the bench.

// File: rtl/spmulti_pkg.sv
// Shared types for the predicated stack multi-element sequencer.
// Assumes nothing beyond plain synthesizable SystemVerilog.
package spmulti_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/spmulti_first_set.sv
// Finds the lowest set bit of a mask at or above a start position.
// Returns W when no qualifying bit exists. Assumes W < 2**IW.
module spmulti_first_set #(
    parameter int W  = 8,
    parameter int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  mask_i,
    input  logic [IW-1:0] from_i,
    output logic [IW-1:0] pos_o
);
    logic [W-1:0] qual;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_qual
            // mark set bits that lie at or above the start position
            assign qual[k] = mask_i[k] && (IW'(k) >= from_i);
        end
    endgenerate

    // priority encode the lowest qualifying bit
    always_comb begin
        pos_o = IW'(W);
        for (int n = W - 1; n >= 0; n--) begin
            if (qual[n]) pos_o = IW'(n);
        end
    end
endmodule

// File: rtl/spmulti_elem_cursor.sv
// Element cursor for one side (source or destination).
// Captures mask and vector flag on load. A vectorised cursor skips
// cleared predicate bits combinationally. A scalar cursor sits at 0.
// Assumes step_i is raised only when pos_o is below the element count.
module spmulti_elem_cursor #(
    parameter int ELEMS = 8,
    parameter int IW    = $clog2(ELEMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ELEMS-1:0] mask_i,
    input  logic             vec_i,
    input  logic             step_i,
    output logic [IW-1:0]    pos_o,
    output logic             vec_o
);
    logic [ELEMS-1:0] mask_q;
    logic             vec_q;
    logic [IW-1:0]    ptr_q;
    logic [IW-1:0]    found;

    spmulti_first_set #(.W(ELEMS), .IW(IW)) u_find (
        .mask_i (mask_q),
        .from_i (ptr_q),
        .pos_o  (found)
    );

    // capture configuration and advance the pointer past each used element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            vec_q  <= 1'b0;
            ptr_q  <= '0;
        end else if (load_i) begin
            mask_q <= mask_i;
            vec_q  <= vec_i;
            ptr_q  <= '0;
        end else if (step_i && vec_q) begin
            ptr_q  <= pos_o + IW'(1);
        end
    end

    // effective element: next active bit when vectorised, else the pointer
    always_comb begin
        pos_o = vec_q ? found : ptr_q;
    end

    assign vec_o = vec_q;
endmodule

// File: rtl/spmulti_req_former.sv
// Forms the stack offset and target register of the current element pair.
// Both results wrap at their field widths.
module spmulti_req_former #(
    parameter int OFF_W      = 12,
    parameter int REG_W      = 6,
    parameter int IW         = 4,
    parameter int ELEM_BYTES = 4
) (
    input  logic [OFF_W-1:0] imm_i,
    input  logic [REG_W-1:0] base_i,
    input  logic [IW-1:0]    src_pos_i,
    input  logic [IW-1:0]    dst_pos_i,
    output logic [OFF_W-1:0] off_o,
    output logic [REG_W-1:0] reg_o
);
    // scale the source element by the element size and add the immediate
    always_comb begin
        off_o = imm_i + OFF_W'(src_pos_i) * OFF_W'(ELEM_BYTES);
        reg_o = base_i + REG_W'(dst_pos_i);
    end
endmodule

// File: rtl/spmulti_seq.sv
// Top of the predicated stack-relative multi-element sequencer.
// Accepts a start while idle, then issues one valid/ready request per
// surviving element pair until a cursor passes the count, or after one
// request when both sides are scalar. Ends with a one-cycle done pulse.
// Assumes the destination register number is already redirected.
module spmulti_seq #(
    parameter int ELEMS      = 8,
    parameter int OFF_W      = 12,
    parameter int REG_W      = 6,
    parameter int ELEM_BYTES = 4,
    localparam int IW        = $clog2(ELEMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IW-1:0]    vl_i,
    input  logic             src_vec_i,
    input  logic [ELEMS-1:0] src_mask_i,
    input  logic             dst_vec_i,
    input  logic [ELEMS-1:0] dst_mask_i,
    input  logic [REG_W-1:0] dst_reg_i,
    input  logic [OFF_W-1:0] imm_i,
    output logic             req_valid_o,
    input  logic             req_ready_i,
    output logic [OFF_W-1:0] req_off_o,
    output logic [REG_W-1:0] req_reg_o,
    output logic             busy_o,
    output logic             done_o
);
    import spmulti_pkg::*;

    run_state_e       state_q;
    logic [IW-1:0]    vl_q;
    logic [OFF_W-1:0] imm_q;
    logic [REG_W-1:0] base_q;
    logic             done_q;

    logic             accept;
    logic             running;
    logic             exhausted;
    logic             hs;
    logic             finish;
    logic [IW-1:0]    src_pos;
    logic [IW-1:0]    dst_pos;
    logic             src_vec;
    logic             dst_vec;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign running   = (state_q == ST_RUN);
    assign exhausted = (src_pos >= vl_q) || (dst_pos >= vl_q);
    assign hs        = req_valid_o && req_ready_i;
    assign finish    = (running && exhausted) || (hs && !src_vec && !dst_vec);

    spmulti_elem_cursor #(.ELEMS(ELEMS), .IW(IW)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .mask_i (src_mask_i),
        .vec_i  (src_vec_i),
        .step_i (hs),
        .pos_o  (src_pos),
        .vec_o  (src_vec)
    );

    spmulti_elem_cursor #(.ELEMS(ELEMS), .IW(IW)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .mask_i (dst_mask_i),
        .vec_i  (dst_vec_i),
        .step_i (hs),
        .pos_o  (dst_pos),
        .vec_o  (dst_vec)
    );

    spmulti_req_former #(
        .OFF_W(OFF_W), .REG_W(REG_W), .IW(IW), .ELEM_BYTES(ELEM_BYTES)
    ) u_form (
        .imm_i     (imm_q),
        .base_i    (base_q),
        .src_pos_i (src_pos),
        .dst_pos_i (dst_pos),
        .off_o     (req_off_o),
        .reg_o     (req_reg_o)
    );

    // run/idle control and capture of the shared configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vl_q    <= '0;
            imm_q   <= '0;
            base_q  <= '0;
        end else if (accept) begin
            state_q <= ST_RUN;
            vl_q    <= (vl_i > IW'(ELEMS)) ? IW'(ELEMS) : vl_i;
            imm_q   <= imm_i;
            base_q  <= dst_reg_i;
        end else if (finish) begin
            state_q <= ST_IDLE;
        end
    end

    // registered end-of-sequence pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign req_valid_o = running && !exhausted;
    assign busy_o      = running;
    assign done_o      = done_q;
endmodule

// File: rtl/spmulti_seq_chk.sv
// Port-level property checker for spmulti_seq, bound to every instance.
module spmulti_seq_chk #(
    parameter int OFF_W = 12,
    parameter int REG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_o,
    input logic             req_ready_i,
    input logic [OFF_W-1:0] req_off_o,
    input logic [REG_W-1:0] req_reg_o,
    input logic             busy_o,
    input logic             done_o
);
    // R9: a stalled request stays valid
    a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o);

    // R9: a stalled request keeps its fields
    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> $stable(req_off_o) && $stable(req_reg_o));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: done only while idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R1: no request outside a sequence
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o);
endmodule

bind spmulti_seq spmulti_seq_chk #(.OFF_W(OFF_W), .REG_W(REG_W)) chk_i (.*);

// File: tb/spmulti_seq_tb.sv
`timescale 1ns/1ps
// Sweep bench: every count 0..8, all vector-flag pairs, a set of mask
// patterns and a pseudo-random ready, compared against a bench-side walk.
module spmulti_seq_tb_top;
    localparam int ELEMS = 8;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [IW-1:0] vl_i = '0;
    logic        src_vec_i = 1'b0;
    logic [7:0]  src_mask_i = '0;
    logic        dst_vec_i = 1'b0;
    logic [7:0]  dst_mask_i = '0;
    logic [5:0]  dst_reg_i = '0;
    logic [11:0] imm_i = '0;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [11:0] req_off_o;
    logic [5:0]  req_reg_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    int exp_off [16];
    int exp_reg [16];
    int exp_n;

    spmulti_seq dut_i (.*);

    always #4 clk = ~clk;

    // watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // expected walk derived from the requirements
    task automatic build_expect(input int vl, input bit sv, input logic [7:0] sm,
                                input bit dv, input logic [7:0] dm,
                                input int base, input int imm);
        int n = (vl > ELEMS) ? ELEMS : vl;
        int i = 0;
        int j = 0;
        exp_n = 0;
        forever begin
            if (sv) while (i < n && !sm[i]) i++;
            if (dv) while (j < n && !dm[j]) j++;
            if (i >= n || j >= n) break;
            exp_off[exp_n] = (imm + 4 * i) & 12'hFFF;
            exp_reg[exp_n] = (base + j) & 6'h3F;
            exp_n++;
            if (!sv && !dv) break;
            if (sv) i++;
            if (dv) j++;
        end
    endtask

    task automatic run_case(input int vl, input bit sv, input logic [7:0] sm,
                            input bit dv, input logic [7:0] dm,
                            input int base, input int imm, input bit inject);
        int got = 0;
        bit seen_done = 0;
        bit held = 0;
        int h_off = 0;
        int h_reg = 0;
        string ctag;
        build_expect(vl, sv, sm, dv, dm, base, imm);
        if (vl > ELEMS)      ctag = "R11";
        else if (vl == 0)    ctag = "R3";
        else if (!sv && !dv) ctag = "R8";
        else if (sv && dv)   ctag = "R6";
        else                 ctag = "R7";
        @(negedge clk);
        start_i    = 1'b1;
        vl_i       = IW'(vl);
        src_vec_i  = sv;
        src_mask_i = sm;
        dst_vec_i  = dv;
        dst_mask_i = dm;
        dst_reg_i  = 6'(base);
        imm_i      = 12'(imm);
        for (int c = 0; c < 300 && !seen_done; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (inject && c == 0) begin
                // R2: start while busy with a different configuration
                start_i = 1'b1; vl_i = 4'd2; imm_i = 12'h7F0; dst_reg_i = 6'd40;
                src_mask_i = 8'h00; dst_mask_i = 8'h00;
            end
            if (held) begin
                chk(req_valid_o === 1'b1, "R9", "stalled valid", int'(req_valid_o), 1);
                chk(int'(req_off_o) == h_off, "R9", "stalled offset", int'(req_off_o), h_off);
                chk(int'(req_reg_o) == h_reg, "R9", "stalled register", int'(req_reg_o), h_reg);
                held = 0;
            end
            if (done_o === 1'b1) begin
                seen_done = 1;
                chk(busy_o === 1'b0, "R10", "busy during done", int'(busy_o), 0);
            end else if (req_valid_o === 1'b1) begin
                req_ready_i = lfsr[0] | lfsr[3];
                if (req_ready_i) begin
                    if (got < exp_n) begin
                        chk(int'(req_off_o) == exp_off[got], sv ? "R4" : "R7",
                            "offset", int'(req_off_o), exp_off[got]);
                        chk(int'(req_reg_o) == exp_reg[got], dv ? "R5" : "R7",
                            "register", int'(req_reg_o), exp_reg[got]);
                    end
                    got++;
                end else begin
                    held = 1;
                    h_off = int'(req_off_o);
                    h_reg = int'(req_reg_o);
                end
            end else begin
                req_ready_i = lfsr[1];
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        start_i = 1'b0;
        chk(seen_done, "R10", "done seen", int'(seen_done), 1);
        chk(got == exp_n, ctag, "request count", got, exp_n);
        @(negedge clk);
        chk(done_o === 1'b0, "R10", "done width", int'(done_o), 0);
        chk(busy_o === 1'b0, "R10", "idle after done", int'(busy_o), 0);
        if (inject) begin
            @(negedge clk);
            chk(busy_o === 1'b0 && req_valid_o === 1'b0, "R2",
                "ignored start left no sequence", int'(busy_o), 0);
        end
    endtask

    initial begin
        logic [7:0] pats [6];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h3C; pats[4] = 8'h81; pats[5] = 8'h12;
        repeat (3) @(negedge clk);
        chk(req_valid_o === 1'b0, "R1", "valid in reset", int'(req_valid_o), 0);
        chk(busy_o === 1'b0, "R1", "busy in reset", int'(busy_o), 0);
        chk(done_o === 1'b0, "R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
            "R1", "quiet after reset", int'(busy_o), 0);

        for (int vl = 0; vl <= ELEMS; vl++)
            for (int f = 0; f < 4; f++)
                for (int a = 0; a < 6; a++)
                    for (int b = 0; b < 6; b++)
                        run_case(vl, f[0], pats[a], f[1], pats[b],
                                 (vl * 5 + 3) & 63, 12'h100 + vl * 16, 1'b0);

        // R4/R5 wrap of offset and register fields
        run_case(8, 1'b1, 8'hFF, 1'b1, 8'hFF, 62, 12'hFF8, 1'b0);
        // R11 counts above ELEMS clamp
        run_case(13, 1'b1, 8'hFF, 1'b1, 8'hFF, 4, 12'h020, 1'b0);
        run_case(15, 1'b1, 8'h0F, 1'b0, 8'h00, 9, 12'h040, 1'b0);
        // R2 start while busy is ignored
        run_case(8, 1'b1, 8'hFF, 1'b1, 8'hFF, 4, 12'h010, 1'b1);
        run_case(6, 1'b1, 8'h2D, 1'b1, 8'h3F, 20, 12'h200, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule